// File: doc/BRIEF.md
# Synaptic Packet Dispatch Cache

This block is a FIFO-organised stream cache placed between a memory-fetch port and a group of processing engines. Each stored word is a packet. The top bits of a packet are a header that names one engine. The remaining bits are a signed two's-complement weight. Packets are filled in contiguous bursts from the fetch side. The block keeps them in arrival order, removes the header from the packet at the head, and offers the weight to the one engine the header names. Delivery uses a per-engine valid/ready handshake. The head never lets a later packet pass it, so a configuration packet placed ahead of an engine's data packets always reaches that engine first.

Two modes exist. In one-shot mode each packet leaves the cache once it is delivered. In circulating mode each delivered packet is written back to the tail in the same cycle. A stream that fits in the cache can then replay without any new fetch. New packets may still be appended in this mode, and they land behind the recirculated one. The mode input is sampled only while the cache is empty. Because a circulating cache never drains, only reset returns it to one-shot mode.

Top module: `synaptic_dispatch_cache`

## Requirements
- R1: A packet is {index, weight}. The index sits in bits [PKT_W-1:WEIGHT_W] and the weight sits in bits [WEIGHT_W-1:0]. The head packet's weight appears unchanged on `pe_weight`.
- R2: While the cache holds data, exactly the bit `pe_valid[index]` of the head packet is set. While the cache is empty, `pe_valid` is all zero, and a ready from an engine removes nothing.
- R3: Packets are delivered strictly in the order they were accepted.
- R4: While the addressed engine holds its ready low, the head packet stays in place. `pe_valid` and `pe_weight` hold their values, and a ready from any other engine has no effect.
- R5: In one-shot mode, a handshake with no write in the same cycle lowers `level` by one.
- R6: In circulating mode, each delivered packet is rewritten to the tail. `level` stays constant, and the stored stream replays in the same order.
- R7: While `level` equals DEPTH, `full` is high and `in_ready` is low. A write attempt in that state changes neither `level` nor the stored contents.
- R8: `empty` is high exactly when `level` is 0, and `full` is high exactly when `level` is DEPTH.
- R9: `circ_mode` takes the value of `mode_sel` only on a clock edge at which `level` is 0. Otherwise it holds its value.
- R10: In circulating mode, a delivery and a write in the same cycle place the recirculated packet in the tail slot and the new packet after it, and `level` rises by one.
- R11: After reset the cache is empty, `level` is 0, `circ_mode` is 0 (one-shot), `pe_valid` is zero and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_sel | input | 1 | Requested mode: 1 selects circulating, 0 selects one-shot |
| in_valid | input | 1 | Fetch side offers a packet |
| in_data | input | PKT_W | Packet {index, weight} |
| in_ready | output | 1 | Cache accepts a packet this cycle |
| pe_valid | output | NUM_PE | One-hot offer to the addressed engine |
| pe_weight | output | WEIGHT_W | Weight of the head packet |
| pe_ready | input | NUM_PE | Per-engine ready |
| full | output | 1 | Cache holds DEPTH packets |
| empty | output | 1 | Cache holds no packets |
| level | output | AW+1 | Number of stored packets |
| circ_mode | output | 1 | Mode in effect: 1 means circulating |

## Verification
The hardest state to reach is a circulating cache that receives a new packet in the very cycle its head is delivered. To get there, the stimulus first selects circulating mode while the cache is empty. It then preloads a short stream with every engine's ready held low, and replays that stream several full laps. After that it raises the write and the ready together on a chosen head. The exact replay order that follows shows where both packets were placed. A second hard case is a full cache that refuses a write. The stimulus fills every slot, pushes an extra marked word, and then drains all slots, so that any overwrite shows up in the delivered weights.

// File: rtl/synaptic_dispatch_cache.sv
module synaptic_dispatch_cache #(
  parameter int NUM_PE   = 8,
  parameter int WEIGHT_W = 16,
  parameter int DEPTH    = 64,
  localparam int IDX_W   = $clog2(NUM_PE),
  localparam int PKT_W   = IDX_W + WEIGHT_W,
  localparam int AW      = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_sel,
  input  logic                in_valid,
  input  logic [PKT_W-1:0]    in_data,
  output logic                in_ready,
  output logic [NUM_PE-1:0]   pe_valid,
  output logic [WEIGHT_W-1:0] pe_weight,
  input  logic [NUM_PE-1:0]   pe_ready,
  output logic                full,
  output logic                empty,
  output logic [AW:0]         level,
  output logic                circ_mode
);

  logic [PKT_W-1:0] mem [DEPTH];
  logic [AW-1:0]    rd_ptr, wr_ptr;
  logic [PKT_W-1:0] head;
  logic [IDX_W-1:0] head_idx;
  logic             pop, push, recirc;

  assign head      = mem[rd_ptr];
  assign head_idx  = head[PKT_W-1:WEIGHT_W];
  assign pe_weight = head[WEIGHT_W-1:0];
  assign empty     = (level == '0);
  assign full      = (level == (AW+1)'(DEPTH));
  assign in_ready  = !full;
  assign pe_valid  = empty ? '0 : (NUM_PE'(1) << head_idx);
  assign pop       = !empty && pe_ready[head_idx];
  assign push      = in_valid && !full;
  assign recirc    = circ_mode && pop;

  always_ff @(posedge clk) begin
    if (recirc) begin
      mem[wr_ptr] <= head;
      if (push) mem[wr_ptr + AW'(1)] <= in_data;
    end else if (push) begin
      mem[wr_ptr] <= in_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr    <= '0;
      wr_ptr    <= '0;
      level     <= '0;
      circ_mode <= 1'b0;
    end else begin
      if (pop) rd_ptr <= rd_ptr + AW'(1);
      wr_ptr <= wr_ptr + AW'(recirc) + AW'(push);
      level  <= level + (AW+1)'(push) - (AW+1)'(pop && !circ_mode);
      if (empty) circ_mode <= mode_sel;
    end
  end

endmodule

module synaptic_dispatch_cache_chk #(
  parameter int NUM_PE   = 8,
  parameter int WEIGHT_W = 16,
  parameter int DEPTH    = 64,
  localparam int IDX_W   = $clog2(NUM_PE),
  localparam int PKT_W   = IDX_W + WEIGHT_W,
  localparam int AW      = $clog2(DEPTH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [NUM_PE-1:0]   pe_valid,
  input logic [WEIGHT_W-1:0] pe_weight,
  input logic [NUM_PE-1:0]   pe_ready,
  input logic                full,
  input logic                empty,
  input logic [AW:0]         level,
  input logic                circ_mode
);
  logic hs, wr;
  assign hs = |(pe_valid & pe_ready);
  assign wr = in_valid && in_ready;

  a_r2_single_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(pe_valid));
  a_r2_empty_silent: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> (pe_valid == '0));
  a_r4_head_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (|(pe_valid & ~pe_ready)) |=> ($stable(pe_weight) && $stable(pe_valid)));
  a_r5_oneshot_drain: assert property (@(posedge clk) disable iff (!rst_n)
    (!circ_mode && hs && !wr) |=> (32'(level) == 32'($past(level)) - 1));
  a_r6_circ_level: assert property (@(posedge clk) disable iff (!rst_n)
    (circ_mode && hs && !wr) |=> (level == $past(level)));
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !in_ready);
  a_r7_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    32'(level) <= DEPTH);
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(full && empty));
  a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
    !empty |=> $stable(circ_mode));
endmodule

bind synaptic_dispatch_cache synaptic_dispatch_cache_chk #(
  .NUM_PE(NUM_PE), .WEIGHT_W(WEIGHT_W), .DEPTH(DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .pe_valid(pe_valid), .pe_weight(pe_weight), .pe_ready(pe_ready),
  .full(full), .empty(empty), .level(level), .circ_mode(circ_mode)
);

// File: tb/synaptic_dispatch_cache_test.sv
module synaptic_dispatch_cache_test;
  localparam int NPE = 8;
  localparam int WW  = 16;
  localparam int DP  = 64;
  localparam int PW  = 19;

  logic clk = 0, rst_n = 0, mode_sel = 0, in_valid = 0;
  logic [PW-1:0]  in_data = '0;
  logic [NPE-1:0] pe_ready = '0;
  logic           in_ready, full, empty, circ_mode;
  logic [NPE-1:0] pe_valid;
  logic [WW-1:0]  pe_weight;
  logic [6:0]     level;
  int errors = 0, checks = 0;

  always #2 clk = ~clk;

  synaptic_dispatch_cache #(.NUM_PE(NPE), .WEIGHT_W(WW), .DEPTH(DP)) uut (
    .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .pe_valid(pe_valid),
    .pe_weight(pe_weight), .pe_ready(pe_ready), .full(full), .empty(empty),
    .level(level), .circ_mode(circ_mode));

  // {expected pe_valid, index, weight}
  localparam logic [26:0] VEC [8] = '{
    {8'h01, 3'd0, 16'h0001}, {8'h80, 3'd7, 16'hFFFF},
    {8'h04, 3'd2, 16'h8000}, {8'h10, 3'd4, 16'h7FFF},
    {8'h02, 3'd1, 16'h1234}, {8'h40, 3'd6, 16'hFEDC},
    {8'h08, 3'd3, 16'h0000}, {8'h20, 3'd5, 16'hA5A5}};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [PW-1:0] p);
    in_valid = 1; in_data = p;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic take(input logic [NPE-1:0] ev, input logic [WW-1:0] ew, input string req);
    check(pe_valid == ev, req, int'(pe_valid), int'(ev));
    check(pe_weight == ew, req, int'(pe_weight), int'(ew));
    pe_ready = '1;
    @(negedge clk);
    pe_ready = '0;
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [PW-1:0] pa, pb, pc, pd;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R11 and R8: reset state
    check(empty && !full && level == 0, "R11", int'(level), 0);
    check(pe_valid == 0 && in_ready && !circ_mode, "R11", int'(pe_valid), 0);

    // R1 R2 R3: table walk
    for (int i = 0; i < 8; i++) push(VEC[i][18:0]);
    check(level == 8, "R8", int'(level), 8);
    for (int i = 0; i < 8; i++) take(VEC[i][26:19], VEC[i][15:0], "R1/R2/R3 table");
    check(empty && level == 0, "R5", int'(level), 0);

    // R4: head stalls while its engine is not ready
    push({3'd5, 16'h0505});
    push({3'd2, 16'h0202});
    pe_ready = 8'h04;
    repeat (3) @(negedge clk);
    pe_ready = '0;
    check(pe_valid == 8'h20 && pe_weight == 16'h0505, "R4", int'(pe_weight), 16'h0505);
    check(level == 2, "R4", int'(level), 2);
    take(8'h20, 16'h0505, "R4 order");
    check(level == 1, "R5", int'(level), 1);
    take(8'h04, 16'h0202, "R4 order");

    // R2: ready while empty removes nothing
    pe_ready = '1;
    repeat (2) @(negedge clk);
    pe_ready = '0;
    check(level == 0 && pe_valid == 0, "R2 empty", int'(level), 0);

    // R7: fill, refused write, drain
    for (int i = 0; i < DP; i++) push({3'(i), 16'(i)});
    check(full && !in_ready && level == 7'(DP), "R7", int'(level), DP);
    push({3'd1, 16'hDEAD});
    check(level == 7'(DP), "R7 refused", int'(level), DP);
    for (int i = 0; i < DP; i++) take(NPE'(1) << (i % 8), 16'(i), "R7/R3 drain");
    check(empty && !full, "R8", int'(level), 0);

    // R9: mode ignored while non-empty, taken when empty
    push({3'd6, 16'h0606});
    mode_sel = 1;
    repeat (2) @(negedge clk);
    check(!circ_mode, "R9 locked", int'(circ_mode), 0);
    take(8'h40, 16'h0606, "R9");
    @(negedge clk);
    check(circ_mode, "R9 sampled", int'(circ_mode), 1);

    // R6: circulating replay
    pa = {3'd0, 16'h0A0A}; pb = {3'd3, 16'hFB0B}; pc = {3'd7, 16'h0C0C};
    pd = {3'd4, 16'h8D0D};
    push(pa); mode_sel = 0; push(pb); push(pc);
    check(circ_mode, "R9 held", int'(circ_mode), 1);
    for (int lap = 0; lap < 3; lap++) begin
      take(8'h01, 16'h0A0A, "R6 replay");
      take(8'h08, 16'hFB0B, "R6 replay");
      take(8'h80, 16'h0C0C, "R6 replay");
      check(level == 3, "R6 level", int'(level), 3);
    end

    // R10: delivery and write together
    check(pe_weight == 16'h0A0A, "R10 head", int'(pe_weight), 16'h0A0A);
    in_valid = 1; in_data = pd; pe_ready = '1;
    @(negedge clk);
    in_valid = 0; pe_ready = '0;
    check(level == 4, "R10 level", int'(level), 4);
    take(8'h08, 16'hFB0B, "R10 order");
    take(8'h80, 16'h0C0C, "R10 order");
    take(8'h01, 16'h0A0A, "R10 order");
    take(8'h10, 16'h8D0D, "R10 order");
    take(8'h08, 16'hFB0B, "R10 order");
    check(level == 4, "R6 level", int'(level), 4);

    // R11: reset leaves circulating mode
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
    check(!circ_mode && empty && level == 0 && pe_valid == 0, "R11 reset", int'(level), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule